// File: doc/BRIEF.md
# USB Control Endpoint Request Sequencer

This block runs the default control pipe (endpoint 0) of a USB device in hardware. A packet engine hands it each SETUP packet, each received OUT data packet and each acknowledgement of a transmitted IN packet. The sequencer decodes the request and chooses the data stage. It then builds IN payloads in chunks of at most one control packet and arms the transmitter for each chunk. Once any OUT data has all arrived, it finishes with a zero-length status packet.

It answers the standard device, interface and endpoint requests and the serial-class line-coding requests. Descriptors come from a small internal ROM that the block walks as a chained list. A newly assigned device address is held back until the status stage of its request has been acknowledged. Anything it cannot answer raises a stall flag, which stays up until the next accepted SETUP.

Top module: `ctl_ep_seq`

## Requirements
- R1: After reset `inArm`, `devAddr`, `addrEnable`, `configValue` and `stall` are all zero.
- R2: A SETUP event whose `setupLen` is not 8 is rejected: `stall` rises and no IN packet is armed.
- R3: SETUP byte 0 is the request type (bit 7 direction, 1 = device-to-host; bits 6:5 kind, 0 = standard, 1 = class; bits 4:0 recipient, 0 = device, 1 = interface, 2 = endpoint). Byte 1 is the request code, bytes 2-3 the value, bytes 4-5 the index and bytes 6-7 the length, all little-endian, with byte 0 on `setupBytes[7:0]`. A request with direction IN or length zero goes straight to the IN data stage. Any other request waits for OUT data and arms nothing until that data arrives.
- R4: GET_STATUS (code 0) sent to the device, an interface or an endpoint returns two zero bytes. GET_INTERFACE (code 10) returns one zero byte.
- R5: SET_CONFIGURATION (code 9) stores value byte 2 on `configValue` and answers with a zero-length packet. GET_CONFIGURATION (code 8) returns that byte.
- R6: SET_ADDRESS (code 5) leaves `devAddr` and `addrEnable` untouched until its zero-length status packet is acknowledged. The acknowledgement then loads value bits 6:0 into `devAddr` and sets `addrEnable`.
- R7: Every IN response is truncated to the request's length field.
- R8: IN data goes out in packets of at most `PKT_BYTES` bytes. A packet shorter than `PKT_BYTES` ends the stage, so a response that is an exact multiple of `PKT_BYTES` ends with a zero-length packet.
- R9: No IN packet is armed while `txBusy` is high. `inArm` is a single-cycle pulse.
- R10: The 7-byte line coding resets to 115200 baud, one stop bit, no parity and 8 data bits (bytes 00 C2 01 00 00 00 08). GET_LINE_CODING (class, code 0x21) returns it. SET_LINE_CODING (class, code 0x20) fills it from OUT data that may be split across packets, and when the 7th byte arrives a zero-length status packet is armed.
- R11: GET_DESCRIPTOR (code 6) walks the ROM chain and matches type (value high byte) and index (value low byte). The ROM holds, in chain order:
  - a device descriptor (18 bytes, type 1);
  - a configuration header (9 bytes, type 2, total length 18);
  - an interface descriptor (9 bytes, type 4);
  - a string descriptor of 4 bytes (type 3);
  - a string descriptor of 6 bytes (type 3, content bytes 0x61 0 0x62 0).
  A configuration match returns the total length rather than the header length.
- R12: An unsupported request, or a descriptor the chain does not hold, raises `stall` and arms nothing. The next accepted SETUP clears `stall`.
- R13: OUT packets and IN acknowledgements that arrive with no stage pending are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| setupValid | input | 1 | SETUP packet received (one-cycle strobe) |
| setupLen | input | 4 | Byte count of that SETUP packet |
| setupBytes | input | 64 | SETUP bytes, byte 0 in bits 7:0 |
| outValid | input | 1 | OUT data packet received (one-cycle strobe) |
| outLen | input | LEN_W | Byte count of the OUT packet |
| outData | input | 8*PKT_BYTES | OUT bytes, byte 0 in bits 7:0 |
| inAck | input | 1 | Armed IN packet acknowledged by host |
| txBusy | input | 1 | Transmit buffer still holds a valid packet |
| inData | output | 8*PKT_BYTES | IN payload, byte 0 in bits 7:0 |
| inLen | output | LEN_W | IN payload length |
| inArm | output | 1 | Arm-transmit strobe |
| devAddr | output | 7 | Device address |
| addrEnable | output | 1 | Address enabled |
| configValue | output | 8 | Current configuration |
| stall | output | 1 | Control endpoint stall flag |

## Verification
The bench aims at the two places where this sequencer differs from a plain request decoder. SET_ADDRESS is checked before and after its status acknowledgement: a design that applied the address at once would drop the host's status handshake at the old address. The descriptor reads are sized to hit truncation to the length field, a length that is an exact multiple of the packet size, and a string index that needs two type matches. A wrong chunking rule would leave the host waiting for a terminating zero-length packet, and a wrong walk would return the wrong string or stall. Further directed cases split line-coding OUT data across two packets, hold the transmitter busy, feed a short SETUP, and inject stray OUT and acknowledge events while idle. Each of these would show up as a spurious or missing arm, or as a corrupted line coding read back afterwards.

// File: rtl/ctl_ep_pkg.sv
package ctl_ep_pkg;

  typedef enum logic [1:0] {
    SRC_ZERO   = 2'd0,
    SRC_CONFIG = 2'd1,
    SRC_LINE   = 2'd2,
    SRC_ROM    = 2'd3
  } respSrc_e;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_WALK   = 3'd1,
    ST_LOAD   = 3'd2,
    ST_INWAIT = 3'd3,
    ST_OUT    = 3'd4
  } ctlState_e;

  // control -> datapath strobes
  typedef struct packed {
    logic       takeSetup;
    logic       loadResp;
    respSrc_e   src;
    logic [7:0] natLen;
    logic       walkStep;
    logic       armTx;
    logic       advance;
    logic       latchAddr;
    logic       setConfig;
    logic       outStart;
    logic       outWrite;
    logic       zeroStatus;
  } ctlStrobe_t;

  localparam logic [7:0] REQ_GET_STATUS  = 8'd0;
  localparam logic [7:0] REQ_SET_ADDRESS = 8'd5;
  localparam logic [7:0] REQ_GET_DESC    = 8'd6;
  localparam logic [7:0] REQ_GET_CONFIG  = 8'd8;
  localparam logic [7:0] REQ_SET_CONFIG  = 8'd9;
  localparam logic [7:0] REQ_GET_IFACE   = 8'd10;
  localparam logic [7:0] REQ_SET_IFACE   = 8'd11;
  localparam logic [7:0] REQ_SET_LINE    = 8'h20;
  localparam logic [7:0] REQ_GET_LINE    = 8'h21;
  localparam logic [7:0] REQ_SET_CTLLINE = 8'h22;

  localparam int LINE_BYTES = 7;
  localparam logic [7:0] DESC_TYPE_CONFIG = 8'd2;

  // Chained descriptor ROM: each entry starts with its length, then its type.
  // A zero length terminates the chain.
  function automatic logic [7:0] descByte(input logic [7:0] a);
    case (a)
      8'd0:  descByte = 8'd18;  8'd1:  descByte = 8'd1;
      8'd3:  descByte = 8'h02;  8'd4:  descByte = 8'd2;
      8'd7:  descByte = 8'd8;   8'd8:  descByte = 8'h34;
      8'd9:  descByte = 8'h12;  8'd10: descByte = 8'h78;
      8'd11: descByte = 8'h56;  8'd13: descByte = 8'h01;
      8'd14: descByte = 8'd1;   8'd15: descByte = 8'd2;
      8'd17: descByte = 8'd1;
      8'd18: descByte = 8'd9;   8'd19: descByte = 8'd2;
      8'd20: descByte = 8'd18;  8'd22: descByte = 8'd1;
      8'd23: descByte = 8'd1;   8'd25: descByte = 8'h80;
      8'd26: descByte = 8'd50;
      8'd27: descByte = 8'd9;   8'd28: descByte = 8'd4;
      8'd32: descByte = 8'd2;   8'd33: descByte = 8'd2;
      8'd36: descByte = 8'd4;   8'd37: descByte = 8'd3;
      8'd38: descByte = 8'h09;  8'd39: descByte = 8'h04;
      8'd40: descByte = 8'd6;   8'd41: descByte = 8'd3;
      8'd42: descByte = 8'h61;  8'd44: descByte = 8'h62;
      default: descByte = 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/ctl_ep_ctrl.sv
module ctl_ep_ctrl
  import ctl_ep_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        setupValid,
  input  logic [3:0]  setupLen,
  input  logic [63:0] setupBytes,
  input  logic        outValid,
  input  logic        inAck,
  input  logic        txBusy,
  input  logic        walkHit,
  input  logic        walkEnd,
  input  logic        lastChunk,
  input  logic        outDone,
  output ctlStrobe_t  strb,
  output logic        stall
);

  ctlState_e state, stateNext;
  logic      stallNext;

  logic [7:0]  reqType, reqCode;
  logic [15:0] reqLen;
  logic [1:0]  reqKind;
  logic [4:0]  reqRecip;
  logic        dataIn;
  logic        unusedIndex;

  assign reqType     = setupBytes[7:0];
  assign reqCode     = setupBytes[15:8];
  assign reqLen      = setupBytes[63:48];
  assign reqKind     = reqType[6:5];
  assign reqRecip    = reqType[4:0];
  assign dataIn      = reqType[7] || (reqLen == 16'd0);
  assign unusedIndex = ^setupBytes[47:16];

  always_comb begin
    ctlStrobe_t s;
    logic       supported;
    logic       isWalk;
    s         = '0;
    supported = 1'b1;
    isWalk    = 1'b0;
    stateNext = state;
    stallNext = stall;

    if (setupValid) begin
      if (setupLen != 4'd8) begin
        stallNext = 1'b1;
        stateNext = ST_IDLE;
      end else begin
        s.takeSetup = 1'b1;
        s.loadResp  = 1'b1;
        s.src       = SRC_ZERO;
        s.natLen    = 8'd0;
        if (reqKind == 2'd0) begin
          case (reqRecip)
            5'd0: begin
              case (reqCode)
                REQ_GET_STATUS:  s.natLen = 8'd2;
                REQ_SET_ADDRESS: s.latchAddr = 1'b1;
                REQ_GET_DESC:    isWalk = 1'b1;
                REQ_GET_CONFIG: begin
                  s.src    = SRC_CONFIG;
                  s.natLen = 8'd1;
                end
                REQ_SET_CONFIG:  s.setConfig = 1'b1;
                default:         supported = 1'b0;
              endcase
            end
            5'd1: begin
              case (reqCode)
                REQ_GET_STATUS: s.natLen = 8'd2;
                REQ_GET_IFACE:  s.natLen = 8'd1;
                REQ_SET_IFACE:  s.natLen = 8'd0;
                default:        supported = 1'b0;
              endcase
            end
            5'd2: begin
              if (reqCode == REQ_GET_STATUS) s.natLen = 8'd2;
              else supported = 1'b0;
            end
            default: supported = 1'b0;
          endcase
        end else if (reqKind == 2'd1) begin
          case (reqCode)
            REQ_SET_LINE:    s.outStart = 1'b1;
            REQ_GET_LINE: begin
              s.src    = SRC_LINE;
              s.natLen = 8'(LINE_BYTES);
            end
            REQ_SET_CTLLINE: s.natLen = 8'd0;
            default:         supported = 1'b0;
          endcase
        end else begin
          supported = 1'b0;
        end

        if (!supported) begin
          s         = '0;
          stallNext = 1'b1;
          stateNext = ST_IDLE;
        end else begin
          stallNext = 1'b0;
          if (isWalk)      stateNext = ST_WALK;
          else if (dataIn) stateNext = ST_LOAD;
          else             stateNext = ST_OUT;
        end
      end
    end else begin
      case (state)
        ST_WALK: begin
          if (walkEnd) begin
            stallNext = 1'b1;
            stateNext = ST_IDLE;
          end else begin
            s.walkStep = 1'b1;
            if (walkHit) stateNext = ST_LOAD;
          end
        end
        ST_LOAD: begin
          if (!txBusy) begin
            s.armTx   = 1'b1;
            stateNext = ST_INWAIT;
          end
        end
        ST_INWAIT: begin
          if (inAck) begin
            s.advance = 1'b1;
            stateNext = lastChunk ? ST_IDLE : ST_LOAD;
          end
        end
        ST_OUT: begin
          if (outValid) begin
            s.outWrite = 1'b1;
            if (outDone) begin
              s.zeroStatus = 1'b1;
              stateNext    = ST_LOAD;
            end
          end
        end
        default: ;
      endcase
    end
    strb = s;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      stall <= 1'b0;
    end else begin
      state <= stateNext;
      stall <= stallNext;
    end
  end

endmodule

// File: rtl/ctl_ep_data.sv
module ctl_ep_data
  import ctl_ep_pkg::*;
#(
  parameter  int PKT_BYTES = 8,
  localparam int LEN_W     = $clog2(PKT_BYTES + 1)
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  ctlStrobe_t             strb,
  input  logic [15:0]            wValue,
  input  logic [15:0]            wLength,
  input  logic [LEN_W-1:0]       outLen,
  input  logic [8*PKT_BYTES-1:0] outData,
  output logic                   walkHit,
  output logic                   walkEnd,
  output logic                   lastChunk,
  output logic                   outDone,
  output logic [8*PKT_BYTES-1:0] inData,
  output logic [LEN_W-1:0]       inLen,
  output logic                   inArm,
  output logic [6:0]             devAddr,
  output logic                   addrEnable,
  output logic [7:0]             configValue
);

  respSrc_e         srcReg;
  logic [15:0]      remain, offset, wLenReg;
  logic [7:0]       romBase, ptr, walkType, walkIdx;
  logic [LEN_W-1:0] chunk, curChunk;
  logic [6:0]       pendAddr;
  logic             pendValid;
  logic [7:0]       outRemain, outOff, outTake;
  logic [7:0]       lineReg [LINE_BYTES];
  logic [8*PKT_BYTES-1:0] nextData;

  // descriptor chain walk
  logic [7:0]  curLen, curType;
  logic [15:0] natDesc;
  assign curLen  = descByte(ptr);
  assign curType = descByte(ptr + 8'd1);
  assign walkEnd = (curLen == 8'd0);
  assign walkHit = !walkEnd && (curType == walkType) && (walkIdx == 8'd0);
  assign natDesc = (walkType == DESC_TYPE_CONFIG) ?
                   {descByte(ptr + 8'd3), descByte(ptr + 8'd2)} : {8'd0, curLen};

  function automatic logic [15:0] min16(input logic [15:0] a, input logic [15:0] b);
    return (a < b) ? a : b;
  endfunction

  assign chunk     = (remain >= 16'(PKT_BYTES)) ? LEN_W'(PKT_BYTES) : LEN_W'(remain);
  assign lastChunk = (curChunk < LEN_W'(PKT_BYTES));
  assign outTake   = (8'(outLen) < outRemain) ? 8'(outLen) : outRemain;
  assign outDone   = (8'(outLen) >= outRemain);

  for (genvar k = 0; k < PKT_BYTES; k++) begin : g_byte
    logic [15:0] pos;
    logic [7:0]  b;
    assign pos = offset + 16'(k);
    always_comb begin
      case (srcReg)
        SRC_CONFIG: b = (pos == 16'd0) ? configValue : 8'h00;
        SRC_LINE:   b = (pos < 16'(LINE_BYTES)) ? lineReg[pos[2:0]] : 8'h00;
        SRC_ROM:    b = descByte(romBase + pos[7:0]);
        default:    b = 8'h00;
      endcase
      if (LEN_W'(k) >= chunk) b = 8'h00;
    end
    assign nextData[8*k +: 8] = b;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      srcReg      <= SRC_ZERO;
      remain      <= '0;
      offset      <= '0;
      wLenReg     <= '0;
      romBase     <= '0;
      ptr         <= '0;
      walkType    <= '0;
      walkIdx     <= '0;
      curChunk    <= '0;
      pendAddr    <= '0;
      pendValid   <= 1'b0;
      outRemain   <= '0;
      outOff      <= '0;
      inData      <= '0;
      inLen       <= '0;
      inArm       <= 1'b0;
      devAddr     <= '0;
      addrEnable  <= 1'b0;
      configValue <= '0;
      lineReg[0]  <= 8'h00;
      lineReg[1]  <= 8'hC2;
      lineReg[2]  <= 8'h01;
      lineReg[3]  <= 8'h00;
      lineReg[4]  <= 8'h00;
      lineReg[5]  <= 8'h00;
      lineReg[6]  <= 8'h08;
    end else begin
      inArm <= 1'b0;
      if (strb.takeSetup) begin
        wLenReg  <= wLength;
        walkType <= wValue[15:8];
        walkIdx  <= wValue[7:0];
        ptr      <= 8'd0;
      end
      if (strb.loadResp) begin
        srcReg  <= strb.src;
        remain  <= min16(16'(strb.natLen), wLength);
        offset  <= '0;
        romBase <= '0;
      end
      if (strb.walkStep) begin
        if (walkHit) begin
          srcReg  <= SRC_ROM;
          romBase <= ptr;
          offset  <= '0;
          remain  <= min16(natDesc, wLenReg);
        end else begin
          if (curType == walkType) walkIdx <= walkIdx - 8'd1;
          ptr <= ptr + curLen;
        end
      end
      if (strb.zeroStatus) begin
        remain <= '0;
        offset <= '0;
      end
      if (strb.armTx) begin
        inData   <= nextData;
        inLen    <= chunk;
        curChunk <= chunk;
        inArm    <= 1'b1;
      end
      if (strb.advance) begin
        offset <= offset + 16'(curChunk);
        remain <= remain - 16'(curChunk);
        if (pendValid) begin
          devAddr    <= pendAddr;
          addrEnable <= 1'b1;
          pendValid  <= 1'b0;
        end
      end
      if (strb.latchAddr) begin
        pendAddr  <= wValue[6:0];
        pendValid <= 1'b1;
      end
      if (strb.setConfig) configValue <= wValue[7:0];
      if (strb.outStart) begin
        outRemain <= 8'(LINE_BYTES);
        outOff    <= '0;
      end
      if (strb.outWrite) begin
        for (int k = 0; k < PKT_BYTES; k++) begin
          if (k < int'(outTake)) lineReg[3'(int'(outOff) + k)] <= outData[8*k +: 8];
        end
        outRemain <= outRemain - outTake;
        outOff    <= outOff + outTake;
      end
    end
  end

endmodule

// File: rtl/ctl_ep_seq.sv
module ctl_ep_seq
  import ctl_ep_pkg::*;
#(
  parameter  int PKT_BYTES = 8,
  localparam int LEN_W     = $clog2(PKT_BYTES + 1)
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   setupValid,
  input  logic [3:0]             setupLen,
  input  logic [63:0]            setupBytes,
  input  logic                   outValid,
  input  logic [LEN_W-1:0]       outLen,
  input  logic [8*PKT_BYTES-1:0] outData,
  input  logic                   inAck,
  input  logic                   txBusy,
  output logic [8*PKT_BYTES-1:0] inData,
  output logic [LEN_W-1:0]       inLen,
  output logic                   inArm,
  output logic [6:0]             devAddr,
  output logic                   addrEnable,
  output logic [7:0]             configValue,
  output logic                   stall
);

  ctlStrobe_t strb;
  logic walkHit, walkEnd, lastChunk, outDone;

  ctl_ep_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .setupValid (setupValid),
    .setupLen   (setupLen),
    .setupBytes (setupBytes),
    .outValid   (outValid),
    .inAck      (inAck),
    .txBusy     (txBusy),
    .walkHit    (walkHit),
    .walkEnd    (walkEnd),
    .lastChunk  (lastChunk),
    .outDone    (outDone),
    .strb       (strb),
    .stall      (stall)
  );

  ctl_ep_data #(.PKT_BYTES(PKT_BYTES)) u_data (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .wValue      (setupBytes[31:16]),
    .wLength     (setupBytes[63:48]),
    .outLen      (outLen),
    .outData     (outData),
    .walkHit     (walkHit),
    .walkEnd     (walkEnd),
    .lastChunk   (lastChunk),
    .outDone     (outDone),
    .inData      (inData),
    .inLen       (inLen),
    .inArm       (inArm),
    .devAddr     (devAddr),
    .addrEnable  (addrEnable),
    .configValue (configValue)
  );

endmodule

// File: rtl/ctl_ep_seq_chk.sv
module ctl_ep_seq_chk #(
  parameter  int PKT_BYTES = 8,
  localparam int LEN_W     = $clog2(PKT_BYTES + 1)
) (
  input logic             clk,
  input logic             rstN,
  input logic             txBusy,
  input logic             inAck,
  input logic             inArm,
  input logic [LEN_W-1:0] inLen,
  input logic [6:0]       devAddr,
  input logic             addrEnable,
  input logic             stall
);

  assert_arm_when_free_R9: assert property (@(posedge clk) disable iff (!rstN)
    inArm |-> !$past(txBusy));

  assert_arm_pulse_R9: assert property (@(posedge clk) disable iff (!rstN)
    inArm |=> !inArm);

  assert_len_bound_R8: assert property (@(posedge clk) disable iff (!rstN)
    inArm |-> (inLen <= LEN_W'(PKT_BYTES)));

  assert_addr_after_ack_R6: assert property (@(posedge clk) disable iff (!rstN)
    (devAddr != $past(devAddr)) |-> $past(inAck));

  assert_enable_after_ack_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(addrEnable) |-> $past(inAck));

  assert_enable_sticky_R6: assert property (@(posedge clk) disable iff (!rstN)
    $past(addrEnable) |-> addrEnable);

  assert_stall_silent_R12: assert property (@(posedge clk) disable iff (!rstN)
    stall |-> !inArm);

endmodule

bind ctl_ep_seq ctl_ep_seq_chk #(.PKT_BYTES(PKT_BYTES)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .txBusy     (txBusy),
  .inAck      (inAck),
  .inArm      (inArm),
  .inLen      (inLen),
  .devAddr    (devAddr),
  .addrEnable (addrEnable),
  .stall      (stall)
);

// File: tb/ctl_ep_seq_test.sv
module ctl_ep_seq_test;
  localparam int PKT = 8;
  localparam int LW  = $clog2(PKT + 1);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic setupValid = 1'b0;
  logic [3:0] setupLen = 4'd0;
  logic [63:0] setupBytes = '0;
  logic outValid = 1'b0;
  logic [LW-1:0] outLen = '0;
  logic [8*PKT-1:0] outData = '0;
  logic inAck = 1'b0;
  logic txBusy = 1'b0;
  logic [8*PKT-1:0] inData;
  logic [LW-1:0] inLen;
  logic inArm;
  logic [6:0] devAddr;
  logic addrEnable;
  logic [7:0] configValue;
  logic stall;

  always #2 clk = ~clk;

  ctl_ep_seq #(.PKT_BYTES(PKT)) uut (.*);

  int nChecks = 0;
  int nFails = 0;
  bit finished = 1'b0;
  logic [7:0] resp [256];
  int respCnt, pktCnt;
  bit gotAll;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic setup(input logic [7:0] rt, input logic [7:0] rq,
                       input logic [15:0] val, input logic [15:0] len);
    @(negedge clk);
    setupValid = 1'b1;
    setupLen   = 4'd8;
    setupBytes = {len, 16'h0000, val, rq, rt};
    @(negedge clk);
    setupValid = 1'b0;
  endtask

  task automatic ack();
    inAck = 1'b1;
    @(negedge clk);
    inAck = 1'b0;
  endtask

  task automatic waitArm(output bit got);
    got = 1'b0;
    for (int i = 0; i < 80; i++) begin
      if (inArm) begin
        got = 1'b1;
        break;
      end
      @(negedge clk);
    end
  endtask

  task automatic collect();
    bit got;
    int n;
    respCnt = 0;
    pktCnt  = 0;
    gotAll  = 1'b0;
    forever begin
      waitArm(got);
      if (!got) return;
      n = int'(inLen);
      for (int b = 0; b < n; b++) resp[respCnt + b] = inData[8*b +: 8];
      respCnt += n;
      pktCnt++;
      ack();
      if (n < PKT) begin
        gotAll = 1'b1;
        return;
      end
    end
  endtask

  task automatic expectNoArm(input int cycles, input string tag);
    bit seen = 1'b0;
    repeat (cycles) begin
      @(negedge clk);
      if (inArm) seen = 1'b1;
    end
    check(!seen, tag, int'(seen), 0);
  endtask

  task automatic sendOut(input int n, input logic [8*PKT-1:0] d);
    @(negedge clk);
    outValid = 1'b1;
    outLen   = LW'(n);
    outData  = d;
    @(negedge clk);
    outValid = 1'b0;
  endtask

  task automatic testReset();
    check(inArm == 0, "R1 inArm", int'(inArm), 0);
    check(devAddr == 0 && addrEnable == 0, "R1 address", int'(devAddr), 0);
    check(configValue == 0, "R1 config", int'(configValue), 0);
    check(stall == 0, "R1 stall", int'(stall), 0);
  endtask

  task automatic testStatus();
    logic [7:0] rts [3] = '{8'h80, 8'h81, 8'h82};
    foreach (rts[i]) begin
      setup(rts[i], 8'd0, 16'd0, 16'd2);
      collect();
      check(gotAll && respCnt == 2 && pktCnt == 1, "R4 get status length", respCnt, 2);
      check(resp[0] == 0 && resp[1] == 0, "R4 get status bytes", int'({resp[0], resp[1]}), 0);
    end
    setup(8'h81, 8'd10, 16'd0, 16'd1);
    collect();
    check(gotAll && respCnt == 1 && resp[0] == 0, "R4 get interface", respCnt, 1);
    setup(8'h80, 8'd0, 16'd0, 16'd1);
    collect();
    check(gotAll && respCnt == 1, "R7 status truncated to 1", respCnt, 1);
  endtask

  task automatic testConfig();
    setup(8'h00, 8'd9, 16'h0003, 16'd0);
    collect();
    check(gotAll && respCnt == 0 && pktCnt == 1, "R3 R5 set config zero-length status", respCnt, 0);
    check(configValue == 8'd3, "R5 config value", int'(configValue), 3);
    setup(8'h80, 8'd8, 16'd0, 16'd1);
    collect();
    check(gotAll && respCnt == 1 && resp[0] == 8'd3, "R5 get config", int'(resp[0]), 3);
  endtask

  task automatic testAddress();
    bit got;
    setup(8'h00, 8'd5, 16'h002A, 16'd0);
    waitArm(got);
    check(got && inLen == 0, "R6 zero-length status armed", int'(inLen), 0);
    repeat (4) @(negedge clk);
    check(devAddr == 0 && addrEnable == 0, "R6 address held before ack", int'(devAddr), 0);
    ack();
    check(devAddr == 7'h2A && addrEnable == 1, "R6 address applied after ack", int'(devAddr), 42);
  endtask

  task automatic testDescriptors();
    setup(8'h80, 8'd6, 16'h0100, 16'd64);
    collect();
    check(gotAll && respCnt == 18 && pktCnt == 3, "R11 device descriptor length", respCnt, 18);
    check(resp[0] == 18 && resp[1] == 1, "R11 device descriptor header", int'(resp[1]), 1);
    setup(8'h80, 8'd6, 16'h0200, 16'd255);
    collect();
    check(gotAll && respCnt == 18, "R11 config total length", respCnt, 18);
    check(resp[1] == 2 && resp[2] == 18 && resp[9] == 9 && resp[10] == 4,
          "R11 config chain bytes", int'(resp[10]), 4);
    setup(8'h80, 8'd6, 16'h0100, 16'd16);
    collect();
    check(gotAll && respCnt == 16 && pktCnt == 3, "R8 exact multiple ends with zero-length", pktCnt, 3);
    setup(8'h80, 8'd6, 16'h0200, 16'd9);
    collect();
    check(gotAll && respCnt == 9 && pktCnt == 2, "R7 descriptor truncated", respCnt, 9);
    setup(8'h80, 8'd6, 16'h0301, 16'd255);
    collect();
    check(gotAll && respCnt == 6 && resp[1] == 3 && resp[2] == 8'h61,
          "R11 second string by index", respCnt, 6);
    setup(8'h80, 8'd6, 16'h0305, 16'd255);
    expectNoArm(40, "R12 missing descriptor arms nothing");
    check(stall == 1, "R12 missing descriptor stalls", int'(stall), 1);
  endtask

  task automatic testRejects();
    setup(8'h80, 8'd0, 16'd0, 16'd2);
    collect();
    check(stall == 0, "R12 stall cleared by accepted setup", int'(stall), 0);
    @(negedge clk);
    setupValid = 1'b1;
    setupLen   = 4'd6;
    setupBytes = {16'd2, 16'd0, 16'd0, 8'd0, 8'h80};
    @(negedge clk);
    setupValid = 1'b0;
    expectNoArm(10, "R2 short setup arms nothing");
    check(stall == 1, "R2 short setup stalls", int'(stall), 1);
    setup(8'h40, 8'd1, 16'd0, 16'd4);
    expectNoArm(10, "R12 vendor request arms nothing");
    check(stall == 1, "R12 vendor request stalls", int'(stall), 1);
  endtask

  task automatic testBusy();
    txBusy = 1'b1;
    setup(8'h80, 8'd0, 16'd0, 16'd2);
    expectNoArm(15, "R9 no arm while busy");
    txBusy = 1'b0;
    collect();
    check(gotAll && respCnt == 2, "R9 arm after busy clears", respCnt, 2);
  endtask

  task automatic testLineCoding();
    logic [7:0] expDef [7] = '{8'h00, 8'hC2, 8'h01, 8'h00, 8'h00, 8'h00, 8'h08};
    logic [7:0] expNew [7] = '{8'h80, 8'h25, 8'h00, 8'h00, 8'h02, 8'h01, 8'h07};
    bit same;
    setup(8'hA1, 8'h21, 16'd0, 16'd7);
    collect();
    same = (respCnt == 7);
    foreach (expDef[i]) if (resp[i] != expDef[i]) same = 1'b0;
    check(gotAll && same, "R10 default line coding", respCnt, 7);

    setup(8'h21, 8'h20, 16'd0, 16'd7);
    expectNoArm(8, "R3 data-out stage waits for OUT data");
    sendOut(4, {32'h0, 8'h00, 8'h00, 8'h25, 8'h80});
    expectNoArm(6, "R10 partial OUT data arms nothing");
    sendOut(3, {40'h0, 8'h07, 8'h01, 8'h02});
    collect();
    check(gotAll && respCnt == 0 && pktCnt == 1, "R10 zero-length status after 7 bytes", respCnt, 0);

    sendOut(3, {40'h0, 8'hFF, 8'hFF, 8'hFF});
    @(negedge clk);
    inAck = 1'b1;
    @(negedge clk);
    inAck = 1'b0;
    expectNoArm(8, "R13 idle OUT and ack ignored");

    setup(8'hA1, 8'h21, 16'd0, 16'd7);
    collect();
    same = (respCnt == 7);
    foreach (expNew[i]) if (resp[i] != expNew[i]) same = 1'b0;
    check(gotAll && same, "R10 R13 line coding updated and untouched while idle", int'(resp[0]), 128);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testStatus();
    testConfig();
    testAddress();
    testDescriptors();
    testRejects();
    testBusy();
    testLineCoding();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

endmodule